// File: doc/BRIEF.md
# Status Register Privilege and Interrupt Controller

This block keeps a 16-bit processor status word and enforces the rules that hang off it. The upper byte holds privilege, trace and interrupt-mask state. The lower byte holds five condition flags. The supervisor flag chooses which of two stack pointers the architectural stack register refers to. While the core runs unprivileged, it protects the upper byte from writes and reports the attempt.

Each cycle the controller compares a 3-bit pending interrupt level against the mask and grants the request when it outranks the mask. Level 7 always gets through, but only once for each time it rises. A grant forces the supervisor state, stops tracing and raises the mask to the granted level. When an instruction retires, the trace bits decide whether a trace exception is requested. Exception sequencing and vector fetch are left to the surrounding core.

Top module: `sr_ctrl`

## Requirements
- R1: After reset `sr_q` reads 16'h2700: bit 13 (supervisor) is 1, the mask in bits 10:8 is 7, and the trace bits 15:14 are 0.
- R2: Bits 12, 11, 7, 6 and 5 of `sr_q` always read 0. The meaningful fields are trace {15,14}, supervisor 13, mask 10:8 and flags 4:0.
- R3: `ssp_sel` is 1, selecting the supervisor stack, exactly when bit 13 of the status word is 1.
- R4: A write with `wr_en`=1 loads `wr_data[4:0]` into bits 4:0 when `wr_mask[0]`=1, in either mode. In supervisor mode, when `wr_mask[1]`=1, it loads bits 15:13 and 10:8 from `wr_data`. The new value is visible after the clock edge.
- R5: In user mode (bit 13 = 0), a write with `wr_mask[1]`=1 leaves the upper byte unchanged and drives `priv_viol` high in that same cycle. `priv_viol` is low in every other case.
- R6: `irq_take` is high in a cycle where `irq_lvl` is greater than the mask. A level of 1 to 6 at or below the mask is not taken, and level 0 is never taken.
- R7: Level 7 is taken whatever the mask, in the first cycle it appears after some other level (or after reset). A level held at 7 is not taken again.
- R8: On a grant, the next status word has bit 13 = 1, bits 15:14 = 0 and mask = the granted level. A grant overrides an upper-byte write in the same cycle, while a lower-byte write in that cycle still takes effect.
- R9: `trace_req` is high exactly when `retire`=1 and either bit 15 = 1, or bit 14 = 1 and `flow_chg`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Status word write strobe |
| wr_mask | input | 2 | Byte lanes: bit 1 upper byte, bit 0 lower byte |
| wr_data | input | 16 | Status word write value |
| retire | input | 1 | Instruction retired this cycle |
| flow_chg | input | 1 | Retiring instruction changed program flow |
| irq_lvl | input | 3 | Pending interrupt level, 0 = none |
| sr_q | output | 16 | Current status word |
| priv_viol | output | 1 | Upper-byte write refused in user mode |
| irq_take | output | 1 | Pending interrupt accepted this cycle |
| trace_req | output | 1 | Trace exception requested |
| ssp_sel | output | 1 | 1 selects the supervisor stack pointer |

## Verification
The assertions check several rules on every cycle:
- the reserved bits stay at zero;
- a refused write leaves the upper byte unchanged;
- a masked level below 7 is never granted;
- a grant leaves supervisor state with tracing off and the granted mask;
- a level-7 grant is never repeated in the next cycle;
- tracing stays silent while both trace bits are clear.

Only the bench's scenarios show the remaining behaviour:
- the exact reset value;
- the write lane merge;
- the grant winning over a same-cycle upper-byte write;
- the two trace modes;
- the re-arming of level 7 after the level drops.

The bench covers these with a per-cycle reference model under directed and pseudo-random traffic.

// File: rtl/sr_ctrl.sv
module sr_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_mask,
  input  logic [15:0] wr_data,
  input  logic        retire,
  input  logic        flow_chg,
  input  logic [2:0]  irq_lvl,
  output logic [15:0] sr_q,
  output logic        priv_viol,
  output logic        irq_take,
  output logic        trace_req,
  output logic        ssp_sel
);
  localparam logic [2:0] TOP_LVL = 3'd7;

  logic [1:0] trc_q;
  logic       sup_q;
  logic [2:0] msk_q;
  logic [4:0] cc_q;
  logic [2:0] prev_q;
  logic       sys_wr;
  logic       top_edge;

  assign sr_q      = {trc_q, sup_q, 2'b00, msk_q, 3'b000, cc_q};
  assign ssp_sel   = sup_q;
  assign sys_wr    = wr_en & wr_mask[1];
  assign priv_viol = sys_wr & ~sup_q;
  assign top_edge  = (irq_lvl == TOP_LVL) && (prev_q != TOP_LVL);
  assign irq_take  = (irq_lvl > msk_q) || top_edge;
  assign trace_req = retire & (trc_q[1] | (trc_q[0] & flow_chg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trc_q  <= 2'b00;
      sup_q  <= 1'b1;
      msk_q  <= TOP_LVL;
      cc_q   <= 5'd0;
      prev_q <= 3'd0;
    end else begin
      prev_q <= irq_lvl;
      if (wr_en && wr_mask[0]) cc_q <= wr_data[4:0];
      if (irq_take) begin
        trc_q <= 2'b00;
        sup_q <= 1'b1;
        msk_q <= irq_lvl;
      end else if (sys_wr && sup_q) begin
        trc_q <= wr_data[15:14];
        sup_q <= wr_data[13];
        msk_q <= wr_data[10:8];
      end
    end
  end
endmodule

module sr_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        retire,
  input logic [2:0]  irq_lvl,
  input logic [15:0] sr_q,
  input logic        priv_viol,
  input logic        irq_take,
  input logic        trace_req
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q & 16'h18E0) == 16'h0000);

  p_user_protect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_viol && !irq_take) |=> $stable(sr_q[15:8]));

  p_masked_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl != 3'd7 && irq_lvl <= sr_q[10:8]) |-> !irq_take);

  p_top_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_lvl == 3'd7) |=> !irq_take);

  p_grant_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (sr_q[13] && sr_q[15:14] == 2'b00 && sr_q[10:8] == $past(irq_lvl)));

  p_trace_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && sr_q[15:14] == 2'b00) |-> !trace_req);
endmodule

bind sr_ctrl sr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .retire(retire), .irq_lvl(irq_lvl),
  .sr_q(sr_q), .priv_viol(priv_viol), .irq_take(irq_take), .trace_req(trace_req)
);

// File: tb/tb_sr_ctrl.sv
module tb_sr_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_mask = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic        retire = 1'b0;
  logic        flow_chg = 1'b0;
  logic [2:0]  irq_lvl = 3'd0;
  logic [15:0] sr_q;
  logic        priv_viol, irq_take, trace_req, ssp_sel;

  int total = 0;
  int bad = 0;
  logic [15:0] m_sr;
  int m_prev;

  sr_ctrl dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_take();
    return (int'(irq_lvl) > int'(m_sr[10:8])) || (irq_lvl == 3'd7 && m_prev != 7);
  endfunction

  task automatic step(input bit we, input logic [1:0] wm, input logic [15:0] wd,
                      input bit rt, input bit fc, input logic [2:0] lv);
    logic [15:0] nx;
    bit tk;
    wr_en = we; wr_mask = wm; wr_data = wd; retire = rt; flow_chg = fc; irq_lvl = lv;
    #1;
    tk = m_take();
    chk("R1 R2 R4 R5 R8 sr_q", sr_q, m_sr);
    chk("R3 ssp_sel", ssp_sel, m_sr[13]);
    chk("R5 priv_viol", priv_viol, we & wm[1] & ~m_sr[13]);
    chk("R6 R7 irq_take", irq_take, tk);
    chk("R9 trace_req", trace_req, rt & (m_sr[15] | (m_sr[14] & fc)));
    @(posedge clk);
    nx = m_sr;
    if (we && wm[0]) nx[4:0] = wd[4:0];
    if (tk) begin
      nx[15:13] = 3'b001;
      nx[10:8] = lv;
    end else if (we && wm[1] && m_sr[13]) begin
      nx[15:13] = wd[15:13];
      nx[10:8] = wd[10:8];
    end
    m_sr = nx;
    m_prev = int'(lv);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_sr = 16'h2700; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset value", sr_q, 16'h2700);
    // R4 supervisor writes, mask 3, trace off, flags
    step(1, 2'b11, 16'hFF1F, 0, 0, 3'd0);
    chk("R2 reserved bits", sr_q & 16'h18E0, 0);
    step(1, 2'b11, 16'h2315, 0, 0, 3'd0);
    // R6 masked and unmasked levels
    step(0, 2'b00, 0, 0, 0, 3'd2);
    step(0, 2'b00, 0, 0, 0, 3'd3);
    step(0, 2'b00, 0, 0, 0, 3'd4);
    chk("R8 grant mask", sr_q[10:8], 4);
    // drop to user mode with T0 set, mask 1
    step(1, 2'b10, 16'h4100, 0, 0, 3'd0);
    chk("R3 user stack", ssp_sel, 0);
    // R9 flow-only trace
    step(0, 2'b00, 0, 1, 0, 3'd0);
    step(0, 2'b00, 0, 1, 1, 3'd0);
    // R5 user write refused, lower byte still written
    step(1, 2'b11, 16'hA70A, 0, 0, 3'd0);
    chk("R5 upper byte kept", sr_q[15:8], 8'h41);
    chk("R4 flags in user", sr_q[4:0], 5'h0A);
    // R7 level 7 edge, held, re-arm
    step(0, 2'b00, 0, 0, 0, 3'd7);
    step(0, 2'b00, 0, 0, 0, 3'd7);
    step(0, 2'b00, 0, 0, 0, 3'd7);
    step(0, 2'b00, 0, 0, 0, 3'd5);
    step(0, 2'b00, 0, 0, 0, 3'd7);
    // R9 every-instruction trace, then R8 grant beats same-cycle write
    step(1, 2'b10, 16'hA200, 0, 0, 3'd0);
    step(0, 2'b00, 0, 1, 0, 3'd0);
    step(1, 2'b11, 16'hC51F, 0, 0, 3'd6);
    chk("R8 grant overrides write", sr_q, 16'h261F);
    for (int i = 0; i < 600; i++) begin
      logic [15:0] d;
      logic [2:0] lv;
      d = 16'($urandom);
      if ($urandom_range(0, 3) == 0) d[13] = 1'b0;
      lv = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd0;
      step($urandom_range(0, 3) == 0, 2'($urandom), d,
           1'($urandom), 1'($urandom), lv);
    end
    rst_n = 1'b0;
    #1;
    m_sr = 16'h2700; m_prev = 0;
    chk("R1 reset again", sr_q, 16'h2700);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 2'b00, 0, 0, 0, 3'd7);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule